// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block works out the reference divider and feedback divider settings for a pixel clock synthesizer. It takes a requested pixel frequency, the reference frequency, a lower and an upper clamp limit, and a chip-variant select. It first clamps the request. It then tries every allowed reference divider in turn, in ascending order. For each one it computes the nearest feedback divider and keeps the candidate whose output frequency lies closest to the clamped request.

When the search ends, the block reports three register-ready bytes and the frequency that the chosen setting actually produces. Software or a mode-set sequencer pulses `start`, waits for the one-cycle `done`, and copies the bytes into the synthesizer. All frequencies are unsigned integers in kHz. Each candidate is rounded with a bit-serial restoring divider, so a search takes a few thousand cycles.

Top module: `pll_div_search`

## Requirements
- R1: The request is clamped before the search. A value below `fmin_khz` becomes `fmin_khz`. The result of that step is then limited to at most `fmax_khz`, so the upper limit wins when the two limits cross.
- R2: The reference divider m is tried from 1 upward. Its limit m_max is 32 when `variant` is 0, and 64 otherwise. The feedback limit n_max is 128 when `variant[1]` is 0, and 2048 when `variant[1]` is 1.
- R3: When m is greater than m_max/2, odd values of m are not tried.
- R4: For each m, n = floor((f*m + floor(ref/2)) / ref), where f is the clamped request. A candidate with n < 1 or n > n_max is dropped. If every candidate is dropped, the block raises `no_solution` with `done`, and all three bytes and `achieved_khz` read 0.
- R5: The error of a candidate is |f - ref*n/m|, compared exactly as a rational number. A later candidate replaces the kept one only when its error is strictly smaller, so on a tie the smaller m is kept.
- R6: For the best m: if m <= m_max/2, then `m_byte` = m-1 and the prescale bit is 0. Otherwise `m_byte` = m/2-1 and the prescale bit is 1.
- R7: When `variant[1]` = 0, `n_byte` = {prescale, (n-1)[6:0]} and `p_byte` = 0.
- R8: When `variant[1]` = 1, `n_byte` = (n-1)[7:0] and `p_byte` = {prescale, (n-1)[10:8], 4'b0000}.
- R9: `achieved_khz` = floor(ref*n/m) for the best setting.
- R10: Handshake:
  - A `start` seen while idle raises `busy` on the next cycle.
  - `done` is a one-cycle pulse with `busy` low.
  - A `start` seen while `busy` is high is ignored.
  - Results hold until the next `done`.
- R11: After reset, `busy`, `done`, `no_solution`, every byte and `achieved_khz` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (sampled while idle) |
| req_khz | input | FW | Requested pixel frequency |
| ref_khz | input | FW | Reference frequency |
| fmin_khz | input | FW | Lower clamp (minimum oscillator frequency) |
| fmax_khz | input | FW | Upper clamp (mode-dependent maximum) |
| variant | input | 2 | 0 oldest, 1 legacy, 2/3 extended |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| no_solution | output | 1 | No candidate passed the range check |
| m_byte | output | 8 | Encoded reference divider |
| n_byte | output | 8 | Encoded feedback divider low byte |
| p_byte | output | 8 | Prescale bit and feedback high bits |
| achieved_khz | output | FW+1 | Frequency of the chosen setting |

## Verification
A corrupted best-candidate register, divider remainder or loop counter does not show up at the ports until `done`. At that point it appears as a wrong byte, a wrong `achieved_khz`, or a `no_solution` raised when it should not be. A fault in the state sequencing shows earlier, as a missing `busy` on the cycle after `start` or as outputs that change while the block is idle. Every vector therefore has its bytes and frequency compared at the `done` strobe. The held outputs are also compared on every idle clock, so a late or spurious change is caught within one cycle.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int FW   = 24,
  parameter int MAXM = 64,
  parameter int NLEG = 128,
  parameter int NEXT = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] req_khz,
  input  logic [FW-1:0] ref_khz,
  input  logic [FW-1:0] fmin_khz,
  input  logic [FW-1:0] fmax_khz,
  input  logic [1:0]    variant,
  output logic          busy,
  output logic          done,
  output logic          no_solution,
  output logic [7:0]    m_byte,
  output logic [7:0]    n_byte,
  output logic [7:0]    p_byte,
  output logic [FW:0]   achieved_khz
);
  localparam int MW = $clog2(MAXM + 2);
  localparam int NB = $clog2(NEXT);
  localparam int DW = FW + NB + 1;
  localparam int EW = DW;
  localparam int XW = EW + MW;
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_DIV, S_EVAL, S_FIN} st_t;
  st_t st;

  logic [FW-1:0] rq, rf, den, rem;
  logic [1:0]    var_q;
  logic [MW-1:0] m, bm;
  logic [NB:0]   bn;
  logic [EW-1:0] berr;
  logic          found, ach;
  logic [DW-1:0] num, quo;
  logic [CW-1:0] cnt;

  logic [FW-1:0] rq_lo, rq_c;
  assign rq_lo = (req_khz < fmin_khz) ? fmin_khz : req_khz;
  assign rq_c  = (rq_lo > fmax_khz) ? fmax_khz : rq_lo;

  logic [MW-1:0] mmax;
  logic [DW-1:0] nmax;
  assign mmax = (var_q == 2'd0) ? MW'(MAXM / 2) : MW'(MAXM);
  assign nmax = var_q[1] ? DW'(NEXT) : DW'(NLEG);

  logic [FW:0] sh, diff;
  logic        ge;
  assign sh   = {rem, num[DW-1]};
  assign diff = sh - {1'b0, den};
  assign ge   = sh >= {1'b0, den};

  logic [DW-1:0] n_num, a_num;
  assign n_num = DW'(rq) * DW'(m) + DW'(rf >> 1);
  assign a_num = DW'(rf) * DW'(bn);

  logic          nvalid, better;
  logic [EW-1:0] lhs, rhs, err;
  assign nvalid = (quo >= DW'(1)) && (quo <= nmax);
  assign lhs    = EW'(rq) * EW'(m);
  assign rhs    = EW'(rf) * EW'(quo[NB:0]);
  assign err    = (lhs >= rhs) ? lhs - rhs : rhs - lhs;
  assign better = !found || (XW'(err) * XW'(bm) < XW'(berr) * XW'(m));

  logic          pre;
  logic [MW-1:0] menc;
  logic [NB-1:0] nm1;
  assign pre  = bm > (mmax >> 1);
  assign menc = pre ? (bm >> 1) - MW'(1) : bm - MW'(1);
  assign nm1  = NB'(bn - (NB+1)'(1));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rq <= '0; rf <= '0; var_q <= '0;
      m <= '0; bm <= '0; bn <= '0; berr <= '0;
      found <= 1'b0; ach <= 1'b0;
      num <= '0; quo <= '0; rem <= '0; den <= '0; cnt <= '0;
      done <= 1'b0; no_solution <= 1'b0;
      m_byte <= '0; n_byte <= '0; p_byte <= '0; achieved_khz <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rq <= rq_c; rf <= ref_khz; var_q <= variant;
          m <= MW'(1); found <= 1'b0; ach <= 1'b0;
          st <= S_STEP;
        end
        S_STEP: begin
          if (m > mmax) begin
            if (found) begin
              num <= a_num; den <= FW'(bm); rem <= '0;
              cnt <= CW'(DW); ach <= 1'b1; st <= S_DIV;
            end else begin
              st <= S_FIN;
            end
          end else if ((m > (mmax >> 1)) && m[0]) begin
            m <= m + MW'(1);
          end else begin
            num <= n_num; den <= rf; rem <= '0;
            cnt <= CW'(DW); st <= S_DIV;
          end
        end
        S_DIV: begin
          num <= num << 1;
          rem <= ge ? diff[FW-1:0] : sh[FW-1:0];
          quo <= {quo[DW-2:0], ge};
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) st <= ach ? S_FIN : S_EVAL;
        end
        S_EVAL: begin
          if (nvalid && better) begin
            found <= 1'b1; bm <= m; bn <= quo[NB:0]; berr <= err;
          end
          m <= m + MW'(1);
          st <= S_STEP;
        end
        S_FIN: begin
          done <= 1'b1;
          no_solution <= !found;
          if (found) begin
            m_byte <= 8'(menc);
            n_byte <= var_q[1] ? nm1[7:0] : {pre, nm1[6:0]};
            p_byte <= var_q[1] ? {pre, nm1[10:8], 4'b0000} : 8'h00;
            achieved_khz <= quo[FW:0];
          end else begin
            m_byte <= '0; n_byte <= '0; p_byte <= '0; achieved_khz <= '0;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       no_solution,
  input logic [7:0] m_byte,
  input logic [7:0] n_byte,
  input logic [7:0] p_byte,
  input logic [1:0] var_q
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_start_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> ($stable(m_byte) && $stable(n_byte) && $stable(p_byte)));
  p_nosol_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_solution) |-> (m_byte == 8'h00 && n_byte == 8'h00 && p_byte == 8'h00));
  p_legacy_p_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_solution && !var_q[1]) |-> (p_byte == 8'h00));
  p_ext_pack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_solution && var_q[1]) |-> (p_byte[3:0] == 4'h0));
  p_old_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_solution && var_q == 2'd0) |-> (m_byte < 8'd16));
endmodule

bind pll_div_search pll_div_search_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .no_solution(no_solution), .m_byte(m_byte), .n_byte(n_byte),
  .p_byte(p_byte), .var_q(var_q)
);

// File: tb/pll_div_search_tb_top.sv
module pll_div_search_tb_top;
  localparam int FW = 24;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [FW-1:0] req_khz = '0, ref_khz = '0, fmin_khz = '0, fmax_khz = '0;
  logic [1:0] variant = '0;
  logic busy, done, no_solution;
  logic [7:0] m_byte, n_byte, p_byte;
  logic [FW:0] achieved_khz;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic have_exp = 1'b0;
  longint e_m = 0, e_n = 0, e_p = 0, e_a = 0, e_ns = 0;

  always #5 clk = ~clk;

  pll_div_search dut_i (.*);

  task automatic chk(input string rq, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  always @(negedge clk) if (rst_n && have_exp && !busy && !done) begin
    chk("R10 hold m", m_byte, e_m);
    chk("R10 hold n", n_byte, e_n);
    chk("R10 hold p", p_byte, e_p);
    chk("R10 hold f", achieved_khz, e_a);
  end

  task automatic model(input longint rq, input longint rf, input longint lo,
                       input longint hi, input int vr);
    longint f = rq, mmax, nmax, bm = 0, bn = 0, be = 0, n, e, nm1, pre;
    bit found = 0;
    if (f < lo) f = lo;
    if (f > hi) f = hi;
    mmax = (vr == 0) ? 32 : 64;
    nmax = (vr >= 2) ? 2048 : 128;
    for (longint m = 1; m <= mmax; m++) begin
      if (m > mmax / 2 && (m % 2) == 1) continue;
      n = (f * m + rf / 2) / rf;
      if (n < 1 || n > nmax) continue;
      e = f * m - rf * n;
      if (e < 0) e = -e;
      if (!found || e * bm < be * m) begin found = 1; bm = m; bn = n; be = e; end
    end
    if (!found) begin e_m = 0; e_n = 0; e_p = 0; e_a = 0; e_ns = 1; end
    else begin
      pre = (bm > mmax / 2) ? 1 : 0;
      e_m = pre ? bm / 2 - 1 : bm - 1;
      nm1 = bn - 1;
      if (vr >= 2) begin
        e_n = nm1 % 256;
        e_p = pre * 128 + (nm1 / 256) * 16;
      end else begin
        e_n = pre * 128 + nm1 % 128;
        e_p = 0;
      end
      e_a = rf * bn / bm;
      e_ns = 0;
    end
  endtask

  task automatic run(input string tag, input longint rq, input longint rf,
                     input longint lo, input longint hi, input int vr,
                     input bit poke);
    @(negedge clk);
    req_khz = FW'(rq); ref_khz = FW'(rf); fmin_khz = FW'(lo); fmax_khz = FW'(hi);
    variant = 2'(vr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R10 busy after start"}, busy, 1);
    have_exp = 1'b0;
    model(rq, rf, lo, hi, vr);
    if (poke) begin
      repeat (40) @(negedge clk);
      req_khz = FW'(rq * 3); variant = 2'(vr ^ 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk({tag, " R10 busy low at done"}, busy, 0);
    chk({tag, " R4 no_solution"}, no_solution, e_ns);
    chk({tag, " R6 m_byte"}, m_byte, e_m);
    chk({tag, " R7/R8 n_byte"}, n_byte, e_n);
    chk({tag, " R8 p_byte"}, p_byte, e_p);
    chk({tag, " R9 achieved"}, achieved_khz, e_a);
    have_exp = 1'b1;
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 no_solution", no_solution, 0);
    chk("R11 bytes", {m_byte, n_byte, p_byte}, 0);
    chk("R11 achieved", achieved_khz, 0);
    rst_n = 1'b1;
    run("R2 R5 ext",       25175, 14318, 10000, 110000, 2, 0);
    run("R2 R7 legacy",    25175, 14318, 10000, 110000, 1, 0);
    run("R2 R6 oldest",    25175, 14318, 10000, 110000, 0, 0);
    run("R1 clamp low",     5000, 14318, 12000,  90000, 2, 0);
    run("R1 clamp high",  200000, 14318, 12000,  65000, 1, 0);
    run("R1 crossed",      40000, 14318, 80000,  50000, 2, 0);
    run("R4 no solution",1000000,     1,     0, 16777215, 1, 0);
    run("R5 tie",          14318, 14318,     0, 200000, 2, 0);
    run("R3 R6 large m",    3001, 50000,     0, 200000, 2, 0);
    run("R3 R6 odd skip",   7013, 27000,     0, 200000, 0, 0);
    run("R8 big n",       108000,   270,     0, 200000, 3, 0);
    run("R7 n limit",     108000,  1000,     0, 200000, 1, 0);
    run("R9 ext",          65000, 14318,     0, 200000, 2, 0);
    run("R10 ignored start",31500, 14318,    0, 200000, 2, 1);
    @(negedge clk);
    chk("R10 ignored start not queued", busy, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule